// File: doc/BRIEF.md
# Instruction Immediate Extractor

This block takes a 32-bit base-format instruction word and returns the constant operand that the word encodes, sign-extended to the datapath width. Depending on the instruction class, that constant sits in one contiguous field or is spread over several separate bit ranges of the word. The block gathers those pieces and puts them back in order. For branch and jump classes it also appends the implied zero at bit 0.

The caller can name the class directly on a three-bit select input. Alternatively, in automatic mode, the block classifies the word itself from bits [6:2] of the opcode. The sign of every produced constant is taken from instruction bit 31, whatever the class. Register-register words and unknown classes yield zero. The datapath is combinational. A parameter can add one output register stage with asynchronous active-low reset.

Top module: `imm_extract`

## Requirements
- R1: Class I (select code 1) yields inst[31:20] sign-extended.
- R2: Class S (select code 2) yields {inst[31:25], inst[11:7]} sign-extended.
- R3: Class B (select code 3) yields {inst[31], inst[7], inst[30:25], inst[11:8], 0} sign-extended, so bit 0 is always 0.
- R4: Class U (select code 4) yields inst[31:12] in bits [31:12], with bits [11:0] always 0.
- R5: Class J (select code 5) yields {inst[31], inst[19:12], inst[20], inst[30:21], 0} sign-extended, so bit 0 is always 0.
- R6: For every class other than R, the top output bit and all bits above the encoded field equal inst[31].
- R7: Class R (select code 0), and the unused select codes 6 and 7, yield an all-zero output.
- R8: When fmt_auto_i is 1, fmt_sel_i is ignored and the class comes from inst[6:2]:
  - 00000, 00100 and 11001 give I.
  - 01000 gives S.
  - 11000 gives B.
  - 00101 and 01101 give U.
  - 11011 gives J.
  - Any other value gives R.
- R9: With REG_OUT=1 the output follows the inputs one clock later and is 0 during reset. With REG_OUT=0 it follows them in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| inst_i | input | 32 | Instruction word |
| fmt_auto_i | input | 1 | 1: classify from opcode; 0: use fmt_sel_i |
| fmt_sel_i | input | 3 | Manual class: 0 R, 1 I, 2 S, 3 B, 4 U, 5 J, 6/7 R |
| imm_o | output | DATA_W | Sign-extended immediate |

## Verification
The bound checker checks these properties on every cycle, against the instruction and class aligned to the output stage:
- sign bit equals inst[31] for every non-R class;
- low field bits of I and S outputs;
- even alignment of B and J outputs;
- cleared low twelve bits of U outputs;
- zero output for R;
- one opcode mapping of automatic mode.

Only the bench can show full bit placement of the scattered branch and jump fields, every opcode mapping, that the manual select is ignored in automatic mode, and the one-cycle latency against the combinational variant. It does this by comparing both variants against a reference model on a hand-worked table and on random words.

// File: rtl/imm_pkg.sv
package imm_pkg;

    localparam int INST_W = 32;
    localparam int MAJ_W  = 5;

    typedef enum logic [2:0] {
        FMT_R = 3'd0,
        FMT_I = 3'd1,
        FMT_S = 3'd2,
        FMT_B = 3'd3,
        FMT_U = 3'd4,
        FMT_J = 3'd5
    } fmt_e;

    // major opcode field inst[6:2]
    localparam logic [MAJ_W-1:0] MAJ_MEM_RD   = 5'b00000;
    localparam logic [MAJ_W-1:0] MAJ_ALU_IMM  = 5'b00100;
    localparam logic [MAJ_W-1:0] MAJ_UPPER_PC = 5'b00101;
    localparam logic [MAJ_W-1:0] MAJ_MEM_WR   = 5'b01000;
    localparam logic [MAJ_W-1:0] MAJ_UPPER    = 5'b01101;
    localparam logic [MAJ_W-1:0] MAJ_COND_BR  = 5'b11000;
    localparam logic [MAJ_W-1:0] MAJ_JUMP_REG = 5'b11001;
    localparam logic [MAJ_W-1:0] MAJ_JUMP     = 5'b11011;

endpackage

// File: rtl/imm_fmt_decode.sv
module imm_fmt_decode
    import imm_pkg::*;
(
    input  logic [MAJ_W-1:0] major_i,
    input  logic             auto_i,
    input  logic [2:0]       manual_i,
    output fmt_e             fmt_o
);

    fmt_e from_op;
    fmt_e from_sel;

    always_comb begin
        case (major_i)
            MAJ_MEM_RD, MAJ_ALU_IMM, MAJ_JUMP_REG: from_op = FMT_I;
            MAJ_MEM_WR:                            from_op = FMT_S;
            MAJ_COND_BR:                           from_op = FMT_B;
            MAJ_UPPER, MAJ_UPPER_PC:               from_op = FMT_U;
            MAJ_JUMP:                              from_op = FMT_J;
            default:                               from_op = FMT_R;
        endcase
    end

    always_comb begin
        case (manual_i)
            3'd1:    from_sel = FMT_I;
            3'd2:    from_sel = FMT_S;
            3'd3:    from_sel = FMT_B;
            3'd4:    from_sel = FMT_U;
            3'd5:    from_sel = FMT_J;
            default: from_sel = FMT_R;
        endcase
    end

    assign fmt_o = auto_i ? from_op : from_sel;

endmodule

// File: rtl/imm_assemble.sv
module imm_assemble
    import imm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INST_W-1:0] inst_i,
    input  fmt_e              fmt_i,
    output logic [DATA_W-1:0] imm_o
);

    logic              sgn;
    logic [INST_W-1:0] raw;

    assign sgn = inst_i[31];

    always_comb begin
        case (fmt_i)
            FMT_I: raw = {{20{sgn}}, inst_i[31:20]};
            FMT_S: raw = {{20{sgn}}, inst_i[31:25], inst_i[11:7]};
            FMT_B: raw = {{19{sgn}}, inst_i[31], inst_i[7], inst_i[30:25],
                          inst_i[11:8], 1'b0};
            FMT_U: raw = {inst_i[31:12], 12'b0};
            FMT_J: raw = {{11{sgn}}, inst_i[31], inst_i[19:12], inst_i[20],
                          inst_i[30:21], 1'b0};
            default: raw = '0;
        endcase
    end

    // widen to the datapath, replicating bit 31
    assign imm_o = DATA_W'($signed(raw));

endmodule

// File: rtl/imm_extract.sv
module imm_extract
    import imm_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       inst_i,
    input  logic              fmt_auto_i,
    input  logic [2:0]        fmt_sel_i,
    output logic [DATA_W-1:0] imm_o
);

    localparam int EXT_W = DATA_W - INST_W;

    typedef struct packed {
        logic [DATA_W-1:0] imm;
    } stage_t;

    fmt_e              fmt_eff;
    logic [DATA_W-1:0] imm_comb;
    stage_t            stage_d;
    stage_t            stage_q;

    imm_fmt_decode u_dec (
        .major_i  (inst_i[6:2]),
        .auto_i   (fmt_auto_i),
        .manual_i (fmt_sel_i),
        .fmt_o    (fmt_eff)
    );

    imm_assemble #(.DATA_W(DATA_W)) u_asm (
        .inst_i (inst_i),
        .fmt_i  (fmt_eff),
        .imm_o  (imm_comb)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.imm = imm_comb;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= stage_d;
            end
        end else begin : g_pass
            assign stage_q = stage_d;
        end
    endgenerate

    assign imm_o = stage_q.imm;

    initial begin
        if (EXT_W < 0) $error("DATA_W must be at least 32");
    end

endmodule

// File: rtl/imm_extract_chk.sv
module imm_extract_chk
    import imm_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       inst,
    input logic [2:0]        fmt,
    input logic              auto_en,
    input logic [DATA_W-1:0] imm
);

    logic [31:0] a_inst;
    logic [2:0]  a_fmt;
    logic        a_auto;

    generate
        if (REG_OUT) begin : g_align
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    a_inst <= '0;
                    a_fmt  <= FMT_R;
                    a_auto <= 1'b0;
                end else begin
                    a_inst <= inst;
                    a_fmt  <= fmt;
                    a_auto <= auto_en;
                end
            end
        end else begin : g_same
            assign a_inst = inst;
            assign a_fmt  = fmt;
            assign a_auto = auto_en;
        end
    endgenerate

    // R1
    i_low_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_fmt == FMT_I |-> imm[10:0] == a_inst[30:20]);

    // R2
    s_low_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_fmt == FMT_S |-> imm[4:0] == a_inst[11:7]);

    // R3 R5
    even_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_fmt == FMT_B || a_fmt == FMT_J) |-> imm[0] == 1'b0);

    // R4
    upper_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_fmt == FMT_U |-> imm[11:0] == 12'h000);

    // R6
    sign_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_fmt != FMT_R |-> imm[DATA_W-1] == a_inst[31]);

    // R7
    reg_class_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_fmt == FMT_R |-> imm == '0);

    // R8
    auto_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_auto && a_inst[6:2] == MAJ_MEM_WR) |-> a_fmt == FMT_S);

endmodule

bind imm_extract imm_extract_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .inst    (inst_i),
    .fmt     (fmt_eff),
    .auto_en (fmt_auto_i),
    .imm     (imm_o)
);

// File: tb/test_imm_extract.sv
module test_imm_extract;

    localparam int N_VEC  = 16;
    localparam int N_RAND = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] inst = '0;
    logic        auto_en = 1'b0;
    logic [2:0]  sel = '0;
    logic [31:0] imm_reg;
    logic [31:0] imm_cmb;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    imm_extract i_imm_extract (
        .clk(clk), .rst_n(rst_n), .inst_i(inst), .fmt_auto_i(auto_en),
        .fmt_sel_i(sel), .imm_o(imm_reg)
    );

    imm_extract #(.REG_OUT(1'b0)) i_imm_extract_comb (
        .clk(clk), .rst_n(rst_n), .inst_i(inst), .fmt_auto_i(auto_en),
        .fmt_sel_i(sel), .imm_o(imm_cmb)
    );

    // {inst, auto, sel, expected}
    localparam logic [67:0] VEC [N_VEC] = '{
        {32'hFFF00093, 1'b1, 3'd0, 32'hFFFFFFFF},  // R1 R8 all-ones I
        {32'h7FF00000, 1'b0, 3'd1, 32'h000007FF},  // R1 manual positive max
        {32'h80000023, 1'b1, 3'd0, 32'hFFFFF800},  // R2 sign only
        {32'h00000FA3, 1'b1, 3'd0, 32'h0000001F},  // R2 low field
        {32'h80000063, 1'b1, 3'd0, 32'hFFFFF000},  // R3 sign only
        {32'h00000FE3, 1'b1, 3'd0, 32'h0000081E},  // R3 bit7 and [11:8]
        {32'h80000037, 1'b1, 3'd0, 32'h80000000},  // R4 upper
        {32'hFFFFFF97, 1'b1, 3'd0, 32'hFFFFF000},  // R4 pc-relative upper
        {32'h800000EF, 1'b1, 3'd0, 32'hFFF00000},  // R5 sign only
        {32'h001000EF, 1'b1, 3'd0, 32'h00000800},  // R5 bit20 -> 11
        {32'h000FF0EF, 1'b1, 3'd0, 32'h000FF000},  // R5 [19:12]
        {32'h7FE0006F, 1'b1, 3'd0, 32'h000007FE},  // R5 [30:21]
        {32'hFFFFFFB3, 1'b1, 3'd0, 32'h00000000},  // R7 reg-reg opcode
        {32'hFFFFFFFF, 1'b0, 3'd7, 32'h00000000},  // R7 unused code 7
        {32'hFFFFFFFF, 1'b0, 3'd6, 32'h00000000},  // R7 unused code 6
        {32'hFFFFFF93, 1'b1, 3'd0, 32'hFFFFFFFF}   // R8 select ignored
    };

    function automatic int ref_class(input logic [31:0] w, input logic a, input logic [2:0] s);
        if (!a) return (s <= 3'd5) ? int'(s) : 0;
        case (w[6:2])
            5'b00000, 5'b00100, 5'b11001: return 1;
            5'b01000: return 2;
            5'b11000: return 3;
            5'b00101, 5'b01101: return 4;
            5'b11011: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] ref_imm(input logic [31:0] w, input logic a, input logic [2:0] s);
        logic [31:0] r;
        int top;
        r = '0;
        top = 0;
        case (ref_class(w, a, s))
            1: begin for (int k = 0; k < 12; k++) r[k] = w[20+k]; top = 11; end
            2: begin
                for (int k = 0; k < 5; k++) r[k] = w[7+k];
                for (int k = 0; k < 7; k++) r[5+k] = w[25+k];
                top = 11;
            end
            3: begin
                for (int k = 0; k < 4; k++) r[1+k] = w[8+k];
                for (int k = 0; k < 6; k++) r[5+k] = w[25+k];
                r[11] = w[7]; r[12] = w[31]; top = 12;
            end
            4: begin for (int k = 12; k < 32; k++) r[k] = w[k]; top = 31; end
            5: begin
                for (int k = 0; k < 10; k++) r[1+k] = w[21+k];
                r[11] = w[20];
                for (int k = 0; k < 8; k++) r[12+k] = w[12+k];
                r[20] = w[31]; top = 20;
            end
            default: top = 31;
        endcase
        for (int k = top + 1; k < 32; k++) r[k] = w[31];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s inst=%h actual=%h expected=%h", req, inst, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic a, input logic [2:0] s);
        @(negedge clk);
        inst = w; auto_en = a; sel = s;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] exp;
        logic [31:0] old;
        logic [4:0]  majors [8] = '{5'b00000, 5'b00100, 5'b00101, 5'b01000,
                                    5'b01101, 5'b11000, 5'b11001, 5'b11011};
        // R9 reset value with live inputs
        inst = 32'hFFF00093; auto_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 reset", imm_reg, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < N_VEC; i++) begin
            apply(VEC[i][67:36], VEC[i][35], VEC[i][34:32]);
            check("R1-R8 table reg", imm_reg, VEC[i][31:0]);
            check("R1-R8 table comb", imm_cmb, VEC[i][31:0]);
            check("R6 table model", ref_imm(inst, auto_en, sel), VEC[i][31:0]);
        end

        // R8 each major opcode in auto mode, manual select set to a wrong class
        for (int i = 0; i < 8; i++) begin
            apply({$urandom()} & 32'hFFFFFF83 | {25'h0, majors[i], 2'b11}, 1'b1, 3'd7);
            check("R8 opcode map", imm_reg, ref_imm(inst, 1'b1, 3'd0));
        end

        // R9 latency: comb follows at once, registered one edge later
        apply(32'h00000000, 1'b0, 3'd0);
        old = imm_reg;
        @(negedge clk);
        inst = 32'h80000000; auto_en = 1'b0; sel = 3'd1;
        #1;
        check("R9 comb same cycle", imm_cmb, 32'hFFFFF800);
        check("R9 reg holds", imm_reg, old);
        @(negedge clk);
        check("R9 reg next cycle", imm_reg, 32'hFFFFF800);

        // R1-R7 random words, both modes
        for (int i = 0; i < N_RAND; i++) begin
            logic [31:0] w;
            w = $urandom();
            if (i % 2 == 0) w[6:2] = majors[i % 8];
            apply(w, i[0] ^ i[2], 3'($urandom_range(0, 7)));
            exp = ref_imm(inst, auto_en, sel);
            check("R1-R7 random reg", imm_reg, exp);
            check("R6 random comb", imm_cmb, exp);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule